// File: doc/BRIEF.md
# DSI Command Packet Transmit Packer

This block turns one host command into the words that a display serial link controller pushes toward its lane logic. A command carries an 8-bit data type. It also carries either two parameter bytes or a byte stream with a 16-bit length. The block writes 32-bit payload words into a payload FIFO and a 24-bit header word into a header FIFO. Both FIFO write ports use valid/ready handshakes.

A short command produces a header only. A long write first streams its payload into the payload FIFO, packed little-endian. It then writes a header whose two parameter bytes hold the byte count. After that it waits for the payload FIFO to report that it has drained, or for a programmable cycle timeout.

Some types only mark timing events: sync edges, end of transmission, null and blanking. These finish at once and write nothing. Commands are refused while the link sits in its ultra-low-power state, and unknown types are refused as well. The block takes one command at a time and shows a busy flag while that command is in flight.

Top module: `dsi_cmd_packer`

## Requirements
- R1: Payload bytes are packed four to a word in arrival order: the first byte goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24.
- R2: When the byte count is not a multiple of four, the last word carries the remaining 1 to 3 bytes in its lowest byte positions, and every unused upper byte is zero.
- R3: For a long write (type 0x29 or 0x39), every payload word is written before the header word, and exactly ceil(count/4) words are written. The header is {count[15:8], count[7:0], type}, with the type in bits 7:0. A count of zero writes the header only.
- R4: The header-only types 0x03, 0x13, 0x23, 0x05, 0x15, 0x37, 0x02, 0x12, 0x22 and 0x32 write one header {p1, p0, type} and no payload. After the header handshake, done pulses with status 0.
- R5: The types 0x01, 0x11, 0x21, 0x31, 0x08, 0x09 and 0x19 write nothing. In the cycle after the start pulse, done is high with status 0 and busy stays low.
- R6: A start pulse taken while link_ulps is high is refused whatever the type. In the next cycle, done is high with status 1 and nothing is written.
- R7: Any other type is refused. In the next cycle, done is high with status 2 and nothing is written.
- R8: After its header handshake, a long write ends with status 0 when pl_empty is seen high. It ends with status 3 when pl_empty has stayed low through the tmo_limit+1 cycles that follow the header handshake; if pl_empty is high in that last cycle, status 0 wins.
- R9: busy is high from acceptance of a header-writing command until its done pulse. A start pulse while busy is ignored: it causes no write and no extra done.
- R10: A write port held not-ready keeps its valid high and its data stable. No byte is lost or reordered under any pattern of backpressure on the byte input or on either FIFO port.
- R11: During and after reset, busy, done, byte_ready, pl_valid and hd_valid are low and status is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command request, taken when not busy |
| cmd_type | input | 8 | Packet data type |
| cmd_p0 | input | 8 | First parameter byte (header-only types) |
| cmd_p1 | input | 8 | Second parameter byte (header-only types) |
| cmd_len | input | 16 | Byte count of a long write |
| link_ulps | input | 1 | Link is in ultra-low-power state |
| tmo_limit | input | TMO_W | Drain timeout in clock cycles |
| byte_valid | input | 1 | Payload byte available |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Packer takes the byte this cycle |
| pl_valid | output | 1 | Payload word valid |
| pl_data | output | WORD_W | Payload word |
| pl_ready | input | 1 | Payload FIFO can take a word |
| pl_empty | input | 1 | Payload FIFO has drained |
| hd_valid | output | 1 | Header word valid |
| hd_data | output | 24 | Header word {byte 2, byte 1, type} |
| hd_ready | input | 1 | Header FIFO can take a word |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 link asleep, 2 bad type, 3 timeout |

## Verification
The drain event and the timeout expiry can land in the same cycle. When they do, the block must choose one outcome. The bench counts cycles from the observed header handshake and raises pl_empty exactly in the final cycle of the timeout window, which must end with status 0. The same long write with pl_empty left low must end with status 3, in the very next cycle and no earlier. A second collision arises when a start pulse arrives while a long write waits for its drain. The bench checks that this pulse neither writes a header nor adds a done pulse.

// File: rtl/dsi_pack_pkg.sv
// Shared types for the command packet packer.
// Assumes an 8-bit data type and a 16-bit byte count in the header.
package dsi_pack_pkg;
    localparam int DT_W  = 8;
    localparam int CNT_W = 16;
    localparam int HDR_W = DT_W + CNT_W;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_LINK_OFF = 2'd1,
        RES_BAD_TYPE = 2'd2,
        RES_TIMEOUT  = 2'd3
    } result_e;

    typedef enum logic [1:0] {
        CLS_BAD,
        CLS_HDR_ONLY,
        CLS_LONG,
        CLS_NOP
    } class_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PAYLOAD,
        PH_HEADER,
        PH_DRAIN
    } phase_e;
endpackage

// File: rtl/dsi_type_decode.sv
// Sorts a packet data type into one of four handling classes.
// Purely combinational; types outside the known set are reported as bad.
module dsi_type_decode
    import dsi_pack_pkg::*;
(
    input  logic [DT_W-1:0] dtype,
    output class_e          cls
);
    // Map the data type onto its handling class.
    always_comb begin
        unique case (dtype)
            8'h03, 8'h13, 8'h23, 8'h05, 8'h15, 8'h37,
            8'h02, 8'h12, 8'h22, 8'h32:                cls = CLS_HDR_ONLY;
            8'h29, 8'h39:                              cls = CLS_LONG;
            8'h01, 8'h11, 8'h21, 8'h31,
            8'h08, 8'h09, 8'h19:                       cls = CLS_NOP;
            default:                                   cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/dsi_byte_packer.sv
// Packs an incoming byte stream into little-endian words.
// Assumes load arrives only while inactive; a word is offered once it
// is full or holds the last byte, and unused upper lanes stay zero.
module dsi_byte_packer
    import dsi_pack_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              active,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              pl_valid,
    output logic [WORD_W-1:0] pl_data,
    input  logic              pl_ready,
    output logic              last_word
);
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [CNT_W-1:0]  remain_q;
    logic [LANE_W-1:0] lane_q;
    logic              full_q;
    logic [7:0]        lane_byte_q [LANES];
    logic              take;
    logic              ship;

    assign byte_ready = active && !full_q;
    assign take       = byte_valid && byte_ready;
    assign pl_valid   = full_q;
    assign ship       = full_q && pl_ready;
    assign last_word  = ship && (remain_q == '0);

    // Track remaining bytes, fill position and word-ready state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            lane_q   <= '0;
            full_q   <= 1'b0;
        end else if (load) begin
            remain_q <= load_len;
            lane_q   <= '0;
            full_q   <= 1'b0;
        end else if (ship) begin
            lane_q   <= '0;
            full_q   <= 1'b0;
        end else if (take) begin
            lane_q   <= lane_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            if (lane_q == LANE_W'(LANES - 1) || remain_q == CNT_W'(1))
                full_q <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Hold one byte lane; cleared after each shipped word.
            always_ff @(posedge clk) begin
                if (!rst_n || load || ship)
                    lane_byte_q[g] <= '0;
                else if (take && lane_q == LANE_W'(g))
                    lane_byte_q[g] <= byte_data;
            end
            assign pl_data[g*8 +: 8] = lane_byte_q[g];
        end
    endgenerate
endmodule

// File: rtl/dsi_drain_timer.sv
// Waits for the payload FIFO to drain, with a cycle-count timeout.
// Assumes arm is pulsed once before run; a drain seen in the final
// window cycle takes priority over expiry.
module dsi_drain_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic             empty,
    input  logic [TMO_W-1:0] limit,
    output logic             drained,
    output logic             expired
);
    logic [TMO_W-1:0] wait_q;

    assign drained = run && empty;
    assign expired = run && !empty && (wait_q >= limit);

    // Count the cycles spent waiting without a drain.
    always_ff @(posedge clk) begin
        if (!rst_n || arm)
            wait_q <= '0;
        else if (run && !drained && !expired)
            wait_q <= wait_q + 1'b1;
    end
endmodule

// File: rtl/dsi_cmd_packer.sv
// Command packet transmit packer: classifies a host command, streams the
// payload of long writes, then writes the header and waits for the drain.
// Assumes cmd_start is a single-cycle pulse; pulses while busy are dropped.
module dsi_cmd_packer
    import dsi_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [7:0]        cmd_type,
    input  logic [7:0]        cmd_p0,
    input  logic [7:0]        cmd_p1,
    input  logic [15:0]       cmd_len,
    input  logic              link_ulps,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              pl_valid,
    output logic [WORD_W-1:0] pl_data,
    input  logic              pl_ready,
    input  logic              pl_empty,
    output logic              hd_valid,
    output logic [23:0]       hd_data,
    input  logic              hd_ready,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    phase_e           phase_q;
    class_e           cls;
    result_e          res_q;
    logic             done_q;
    logic             long_q;
    logic [HDR_W-1:0] hdr_q;
    logic             accept;
    logic             load_long;
    logic             last_word;
    logic             arm;
    logic             drained;
    logic             expired;

    dsi_type_decode u_decode (
        .dtype (cmd_type),
        .cls   (cls)
    );

    assign accept    = cmd_start && (phase_q == PH_IDLE);
    assign load_long = accept && !link_ulps && (cls == CLS_LONG);
    assign arm       = (phase_q == PH_HEADER) && hd_ready && long_q;

    dsi_byte_packer #(.WORD_W(WORD_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_long),
        .load_len   (cmd_len),
        .active     (phase_q == PH_PAYLOAD),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .pl_valid   (pl_valid),
        .pl_data    (pl_data),
        .pl_ready   (pl_ready),
        .last_word  (last_word)
    );

    dsi_drain_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .run     (phase_q == PH_DRAIN),
        .empty   (pl_empty),
        .limit   (tmo_limit),
        .drained (drained),
        .expired (expired)
    );

    // Sequence each command through payload, header and drain phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            res_q   <= RES_OK;
            done_q  <= 1'b0;
            long_q  <= 1'b0;
            hdr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (link_ulps) begin
                            done_q <= 1'b1;
                            res_q  <= RES_LINK_OFF;
                        end else begin
                            unique case (cls)
                                CLS_BAD: begin
                                    done_q <= 1'b1;
                                    res_q  <= RES_BAD_TYPE;
                                end
                                CLS_NOP: begin
                                    done_q <= 1'b1;
                                    res_q  <= RES_OK;
                                end
                                CLS_HDR_ONLY: begin
                                    hdr_q   <= {cmd_p1, cmd_p0, cmd_type};
                                    long_q  <= 1'b0;
                                    phase_q <= PH_HEADER;
                                end
                                CLS_LONG: begin
                                    hdr_q   <= {cmd_len[15:8], cmd_len[7:0], cmd_type};
                                    long_q  <= 1'b1;
                                    phase_q <= (cmd_len == '0) ? PH_HEADER : PH_PAYLOAD;
                                end
                            endcase
                        end
                    end
                end
                PH_PAYLOAD: begin
                    if (last_word)
                        phase_q <= PH_HEADER;
                end
                PH_HEADER: begin
                    if (hd_ready) begin
                        if (long_q) begin
                            phase_q <= PH_DRAIN;
                        end else begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                            res_q   <= RES_OK;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (drained || expired) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                        res_q   <= drained ? RES_OK : RES_TIMEOUT;
                    end
                end
            endcase
        end
    end

    assign hd_valid = (phase_q == PH_HEADER);
    assign hd_data  = hdr_q;
    assign busy     = (phase_q != PH_IDLE);
    assign done     = done_q;
    assign status   = res_q;
endmodule

// File: rtl/dsi_cmd_packer_chk.sv
// Protocol checker for the command packer, bound to every instance.
// Assumes synchronous active-low reset; all properties idle during reset.
module dsi_cmd_packer_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              link_ulps,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic              byte_ready,
    input logic              pl_valid,
    input logic              pl_ready,
    input logic [WORD_W-1:0] pl_data,
    input logic              hd_valid,
    input logic              hd_ready,
    input logic [23:0]       hd_data
);
    AST_PL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid && !pl_ready |=> pl_valid && $stable(pl_data));                     // R10
    AST_HD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hd_valid && !hd_ready |=> hd_valid && $stable(hd_data));                     // R10
    AST_PAYLOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hd_valid |-> !pl_valid);                                                     // R3
    AST_ULPS_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && !busy && link_ulps |=> done && status == 2'd1 && !hd_valid);    // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pl_valid && !hd_valid && !byte_ready);                            // R9
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                             // R9
endmodule

bind dsi_cmd_packer dsi_cmd_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .link_ulps  (link_ulps),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .byte_ready (byte_ready),
    .pl_valid   (pl_valid),
    .pl_ready   (pl_ready),
    .pl_data    (pl_data),
    .hd_valid   (hd_valid),
    .hd_ready   (hd_ready),
    .hd_data    (hd_data)
);

// File: tb/dsi_cmd_packer_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table for single-cycle commands, then
// directed long writes, timeout, collisions and reset.
module dsi_cmd_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [7:0]  cmd_type = '0, cmd_p0 = '0, cmd_p1 = '0;
    logic [15:0] cmd_len = '0;
    logic        link_ulps = 1'b0;
    logic [15:0] tmo_limit = 16'd200;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic        pl_valid;
    logic [31:0] pl_data;
    logic        pl_ready = 1'b0;
    logic        pl_empty = 1'b0;
    logic        hd_valid;
    logic [23:0] hd_data;
    logic        hd_ready = 1'b0;
    logic        busy, done;
    logic [1:0]  status;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dsi_cmd_packer u_dsi_cmd_packer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_type(cmd_type),
        .cmd_p0(cmd_p0), .cmd_p1(cmd_p1), .cmd_len(cmd_len), .link_ulps(link_ulps),
        .tmo_limit(tmo_limit), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_ready(pl_ready), .pl_empty(pl_empty), .hd_valid(hd_valid),
        .hd_data(hd_data), .hd_ready(hd_ready), .busy(busy), .done(done),
        .status(status)
    );

    typedef struct packed {
        logic       ulps;
        logic [7:0] dt;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [1:0] st;
        logic       hdr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h03, 8'h00, 8'h00, 2'd0, 1'b1},
        '{1'b0, 8'h13, 8'hA5, 8'h00, 2'd0, 1'b1},
        '{1'b0, 8'h23, 8'h12, 8'h34, 2'd0, 1'b1},
        '{1'b0, 8'h05, 8'h11, 8'h00, 2'd0, 1'b1},
        '{1'b0, 8'h15, 8'h36, 8'h48, 2'd0, 1'b1},
        '{1'b0, 8'h37, 8'h04, 8'h00, 2'd0, 1'b1},
        '{1'b0, 8'h32, 8'h00, 8'h00, 2'd0, 1'b1},
        '{1'b0, 8'h12, 8'h5A, 8'hC3, 2'd0, 1'b1},
        '{1'b0, 8'h01, 8'h77, 8'h88, 2'd0, 1'b0},
        '{1'b0, 8'h19, 8'h00, 8'h00, 2'd0, 1'b0},
        '{1'b0, 8'h08, 8'h00, 8'h00, 2'd0, 1'b0},
        '{1'b0, 8'h3E, 8'h00, 8'h00, 2'd2, 1'b0},
        '{1'b0, 8'hFF, 8'h00, 8'h00, 2'd2, 1'b0},
        '{1'b1, 8'h05, 8'h10, 8'h00, 2'd1, 1'b0},
        '{1'b1, 8'h29, 8'h00, 8'h00, 2'd1, 1'b0},
        '{1'b1, 8'h7F, 8'h00, 8'h00, 2'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [7:0] pat(input int k, input int len);
        return 8'((k * 37 + len * 5 + 1) & 255);
    endfunction

    // Issue a long write, collect words and header under backpressure.
    task automatic long_wr(input logic [7:0] dt, input int len, input bit drain);
        logic [31:0] got [8];
        int          nw = 0;
        int          nw_at_hdr = 0;
        bit          hseen = 0;
        logic [23:0] hdr_first = '0;
        logic [23:0] hdr_got = '0;
        int          hwait = 0;
        int          exp_nw;
        @(negedge clk);
        cmd_start = 1'b1; cmd_type = dt; cmd_len = 16'(len);
        @(negedge clk);
        cmd_start = 1'b0;
        fork
            begin
                for (int i = 0; i < len; i++) begin
                    @(negedge clk);
                    byte_valid = 1'b1;
                    byte_data  = pat(i, len);
                    while (!byte_ready) @(negedge clk);
                end
                if (len > 0) begin
                    @(negedge clk);
                    byte_valid = 1'b0;
                end
            end
            begin
                int cyc = 0;
                while (!hseen) begin
                    pl_ready = (cyc % 3) != 1;
                    if (hd_valid) begin
                        if (hwait == 0) hdr_first = hd_data;
                        hwait++;
                    end
                    hd_ready = (hwait >= 3);
                    if (pl_valid && pl_ready) begin
                        if (nw < 8) got[nw] = pl_data;
                        nw++;
                    end
                    if (hd_valid && hd_ready) begin
                        hseen     = 1;
                        hdr_got   = hd_data;
                        nw_at_hdr = nw;
                    end
                    cyc++;
                    @(negedge clk);
                end
                pl_ready = 1'b0;
                hd_ready = 1'b0;
            end
        join
        exp_nw = (len + 3) / 4;
        chk(nw_at_hdr == exp_nw && nw == exp_nw, "R3 word count before header", 32'(nw), 32'(exp_nw));
        chk(hdr_got == {8'(len >> 8), 8'(len), dt}, "R3 header", 32'(hdr_got), 32'({8'(len >> 8), 8'(len), dt}));
        chk(hdr_first == hdr_got, "R10 header stable under stall", 32'(hdr_got), 32'(hdr_first));
        for (int w = 0; w < exp_nw && w < 8; w++) begin
            logic [31:0] e = '0;
            for (int l = 0; l < 4; l++)
                if (w * 4 + l < len) e[l*8 +: 8] = pat(w * 4 + l, len);
            chk(got[w] == e, (w * 4 + 4 > len) ? "R2 tail word" : "R1 full word", got[w], e);
        end
        chk(busy && !done, "R9 busy while draining", {30'd0, busy, done}, 32'd2);
        if (drain) begin
            pl_empty = 1'b1;
            @(negedge clk);
            pl_empty = 1'b0;
            chk(done && status == 2'd0 && !busy, "R8 drain completes", {29'd0, done, status}, 32'h4);
        end
    endtask

    initial begin
        #400us;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pl_valid && !hd_valid && !byte_ready && status == 2'd0,
            "R11 in reset", {26'd0, busy, done, pl_valid, hd_valid, status}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pl_valid && !hd_valid && !byte_ready && status == 2'd0,
            "R11 after reset", {26'd0, busy, done, pl_valid, hd_valid, status}, 32'd0);

        // Table walk: header-only, no-op, refused commands (R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmd_start = 1'b1; cmd_type = VEC[i].dt; cmd_p0 = VEC[i].p0;
            cmd_p1 = VEC[i].p1; link_ulps = VEC[i].ulps;
            @(negedge clk);
            cmd_start = 1'b0; link_ulps = 1'b0;
            if (VEC[i].hdr) begin
                chk(hd_valid && busy && !done && !pl_valid, "R4 header offered",
                    {29'd0, hd_valid, busy, done}, 32'd6);
                chk(hd_data == {VEC[i].p1, VEC[i].p0, VEC[i].dt}, "R4 header content",
                    32'(hd_data), 32'({VEC[i].p1, VEC[i].p0, VEC[i].dt}));
                hd_ready = 1'b1;
                @(negedge clk);
                hd_ready = 1'b0;
                chk(done && status == 2'd0 && !busy && !hd_valid, "R4 done after header",
                    {29'd0, done, status}, 32'h4);
            end else begin
                chk(done && !busy && !hd_valid && !pl_valid,
                    VEC[i].st == 2'd1 ? "R6 refused, no write" :
                    VEC[i].st == 2'd2 ? "R7 refused, no write" : "R5 no-op, no write",
                    {28'd0, done, busy, hd_valid, pl_valid}, 32'h8);
                chk(status == VEC[i].st,
                    VEC[i].st == 2'd1 ? "R6 status" : VEC[i].st == 2'd2 ? "R7 status" : "R5 status",
                    32'(status), 32'(VEC[i].st));
            end
        end

        // Long writes: aligned, tails of 1..3, zero length (R1 R2 R3 R10)
        long_wr(8'h29, 1, 1);
        long_wr(8'h29, 2, 1);
        long_wr(8'h39, 3, 1);
        long_wr(8'h39, 4, 1);
        long_wr(8'h29, 5, 1);
        long_wr(8'h39, 8, 1);
        long_wr(8'h29, 11, 1);
        long_wr(8'h39, 0, 1);

        // R8: timeout with pl_empty held low
        tmo_limit = 16'd20;
        long_wr(8'h29, 6, 0);
        begin
            bit early = 0;
            repeat (20) begin
                @(negedge clk);
                if (done) early = 1;
            end
            chk(!early, "R8 no early timeout", 32'(early), 32'd0);
            @(negedge clk);
            chk(done && status == 2'd3 && !busy, "R8 timeout status", {29'd0, done, status}, 32'h7);
        end

        // R8: drain in the last window cycle beats the timeout
        long_wr(8'h39, 7, 0);
        repeat (20) @(negedge clk);
        pl_empty = 1'b1;
        @(negedge clk);
        pl_empty = 1'b0;
        chk(done && status == 2'd0, "R8 drain wins tie", {29'd0, done, status}, 32'h4);

        // R9: start pulse while busy is ignored
        tmo_limit = 16'd200;
        long_wr(8'h29, 4, 0);
        cmd_start = 1'b1; cmd_type = 8'h05; cmd_p0 = 8'hEE;
        @(negedge clk);
        cmd_start = 1'b0;
        begin
            bit bad = 0;
            repeat (3) begin
                if (hd_valid || done || !busy) bad = 1;
                @(negedge clk);
            end
            chk(!bad, "R9 start while busy ignored", 32'(bad), 32'd0);
        end
        pl_empty = 1'b1;
        @(negedge clk);
        pl_empty = 1'b0;
        chk(done && status == 2'd0, "R9 original command finishes", {29'd0, done, status}, 32'h4);
        @(negedge clk);
        chk(!hd_valid && !busy && !done, "R9 no queued command", {29'd0, hd_valid, busy, done}, 32'd0);

        // R11: reset in the middle of a payload
        cmd_start = 1'b1; cmd_type = 8'h39; cmd_len = 16'd8;
        @(negedge clk);
        cmd_start = 1'b0;
        byte_valid = 1'b1; byte_data = 8'h42;
        repeat (2) @(negedge clk);
        byte_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pl_valid && !hd_valid && !byte_ready && status == 2'd0,
            "R11 mid-payload reset", {26'd0, busy, done, pl_valid, hd_valid, status}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !byte_ready, "R11 idle after reset", {30'd0, busy, byte_ready}, 32'd0);

        summary();
        $finish;
    end
endmodule